// File: doc/BRIEF.md
# Parallel Port Handshake Controller

This block sits on a simple register bus and runs two 8-bit parallel ports. Port B is output only. Port C is bidirectional and has three registers: a direction register, a direct data register and a separate latched-data register. Two strobe lines coordinate transfers with an external peer. The input strobe (A) is edge-detected, and the output strobe (B) is driven by the block. A control register selects one of four operating modes, the active edge of strobe A, the polarity of strobe B and the interrupt enable. It also holds a read-only event flag.

In simple strobed mode, every write to port B produces a two-cycle strobe B pulse, and every active strobe A edge captures the port C pins into the latch. In full input handshake mode, strobe B is a ready line. In full output handshake mode, strobe B signals that fresh data is waiting and strobe A acknowledges it. A three-state output variant drives the latched value onto all port C lines only while strobe A is held at its active level. Strobe A passes through a two-flop synchronizer before edge detection, so capture and flag events follow the pin by three clock edges.

Top module: `pio_hs_ctrl`

## Requirements
- R1: In simple mode (control bits [5:4] = 00), a bus write to offset 2 updates `pb_o` and makes strobe B active for exactly two clock cycles, starting the cycle after the write edge. A write in another mode updates `pb_o` without a pulse.
- R2: Control bit 2 selects the strobe B polarity: 0 means active-high, 1 means active-low. The idle level is the inverse of the active level.
- R3: Control bit 3 selects the active edge of strobe A: 0 means rising, 1 means falling. In simple mode and full input mode, an active edge copies `pc_i` into the latched-data register (read at offset 3) and sets the flag (control bit 7). An inactive edge does neither.
- R4: `irq_o` is high one cycle after the flag and the interrupt enable (control bit 6) are both set, and low one cycle after either one is clear.
- R5: The flag clears only when the latched-data register is accessed after a control read that returned the flag set. Accessing the latch without that prior read leaves the flag set. Bus writes to control bit 7 are ignored.
- R6: Direction register (offset 4): a 1 bit makes that line an output. `pc_oe` follows the direction register, and `pc_o` carries the direct data register (offset 1). A read of offset 1 returns the pin level for input bits and the register value for output bits.
- R7: Full input mode (bits [5:4] = 01): entering the mode asserts strobe B, an active strobe A edge negates it, and a read of the latch reasserts it.
- R8: Full output mode (bits [5:4] = 10): a write to the latch stores the data in both the latch and the direct data register and asserts strobe B. An active strobe A edge negates strobe B and leaves the latch unchanged.
- R9: Three-state output mode (bits [5:4] = 11): while strobe A sits at its active level, `pc_oe` is all ones and `pc_o` equals the latch. Otherwise `pc_oe` follows the direction register. Strobe B behaves as in R8.
- R10: After reset, the control register reads 0x00, all port C lines are inputs, strobe B is inactive (low) and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read |
| irq_o | output | 1 | Interrupt request |
| stra_i | input | 1 | Peer strobe (asynchronous) |
| strb_o | output | 1 | Handshake / pulse strobe to the peer |
| pb_o | output | 8 | Port B output lines |
| pc_i | input | 8 | Port C pin levels |
| pc_o | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C per-line output enables |

## Verification
Capture is tried with random pin values and random strobe A transitions under both edge settings. Rising, falling and repeated-level steps show whether the edge select gates the latch or whether every level change slips through. Directed sequences take each handshake mode through its ready, capture, acknowledge and re-arm steps. A latch access with and without the prior control read tells the correct flag-clear sequence apart from a bare clear-on-access. The three-state test raises and drops strobe A so that the output enables are seen to follow the live strobe level and not the last edge.

// File: rtl/pio_hs_pkg.sv
package pio_hs_pkg;

  typedef enum logic [1:0] {
    MODE_SIMPLE   = 2'b00,
    MODE_FULL_IN  = 2'b01,
    MODE_FULL_OUT = 2'b10,
    MODE_TRI_OUT  = 2'b11
  } pio_mode_e;

  // control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic      flag;
    logic      irq_en;
    pio_mode_e mode;
    logic      stra_fall;
    logic      strb_low;
    logic [1:0] spare;
  } pio_ctrl_t;

endpackage

// File: rtl/pio_stra_detect.sv
module pio_stra_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stra_i,
  input  logic fall_sel,
  output logic act_edge,
  output logic act_level
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] sh_q;
  logic           sync_lvl;
  logic           prev_lvl;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[LEN-2:0], stra_i};
  end

  assign sync_lvl  = sh_q[STAGES-1];
  assign prev_lvl  = sh_q[STAGES];
  assign act_level = sync_lvl ^ fall_sel;
  assign act_edge  = fall_sel ? (~sync_lvl & prev_lvl) : (sync_lvl & ~prev_lvl);
endmodule

// File: rtl/pio_strb_ctrl.sv
module pio_strb_ctrl
  import pio_hs_pkg::*;
#(
  parameter int PULSE = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  pio_mode_e mode,
  input  logic      strb_low,
  input  logic      ctrl_wr,
  input  pio_mode_e new_mode,
  input  logic      wr_pb,
  input  logic      wr_latch,
  input  logic      rd_latch,
  input  logic      act_edge,
  output logic      strb_o,
  output logic      strb_act,
  output logic      pulse_busy
);
  localparam int CW = $clog2(PULSE + 1);

  logic [CW-1:0] pulse_q;
  logic          hs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= '0;
    end else if (wr_pb && mode == MODE_SIMPLE) begin
      pulse_q <= CW'(PULSE);
    end else if (pulse_q != '0) begin
      pulse_q <= pulse_q - 1'b1;
    end
  end

  // later statements take priority
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
    end else begin
      if (ctrl_wr) hs_q <= (new_mode == MODE_FULL_IN);
      if (mode == MODE_FULL_IN) begin
        if (rd_latch) hs_q <= 1'b1;
        if (act_edge) hs_q <= 1'b0;
      end else if (mode[1]) begin
        if (act_edge) hs_q <= 1'b0;
        if (wr_latch) hs_q <= 1'b1;
      end
    end
  end

  assign pulse_busy = (pulse_q != '0);
  assign strb_act   = (mode == MODE_SIMPLE) ? pulse_busy : hs_q;
  assign strb_o     = strb_act ^ strb_low;
endmodule

// File: rtl/pio_portc_drive.sv
module pio_portc_drive
  import pio_hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  pio_mode_e     mode,
  input  logic          act_level,
  input  logic [DW-1:0] ddr,
  input  logic [DW-1:0] pdat,
  input  logic [DW-1:0] latch,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe
);
  logic tri_on;
  assign tri_on = (mode == MODE_TRI_OUT) && act_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o  <= '0;
      pc_oe <= '0;
    end else begin
      pc_oe <= tri_on ? '1 : ddr;
      pc_o  <= tri_on ? latch : pdat;
    end
  end
endmodule

// File: rtl/pio_hs_ctrl.sv
module pio_hs_ctrl
  import pio_hs_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE       = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  input  logic          stra_i,
  output logic          strb_o,
  output logic [DW-1:0] pb_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe
);
  localparam logic [AW-1:0] OFS_CTRL  = AW'(0);
  localparam logic [AW-1:0] OFS_PCDAT = AW'(1);
  localparam logic [AW-1:0] OFS_PB    = AW'(2);
  localparam logic [AW-1:0] OFS_LATCH = AW'(3);
  localparam logic [AW-1:0] OFS_DDR   = AW'(4);

  pio_mode_e     mode_q;
  logic          ie_q, fall_q, low_q, flag_q, arm_q;
  logic [DW-1:0] pb_q, pdat_q, ddr_q, latch_q;
  pio_ctrl_t     ctrl_view, ctrl_in;

  logic wr, rd;
  logic wr_ctrl, rd_ctrl, wr_pb, wr_pcdat, wr_ddr, wr_latch, rd_latch;
  logic lat_access, cap_edge, act_edge, act_level;
  logic strb_act, pulse_busy;

  assign wr       = bus_sel &  bus_we;
  assign rd       = bus_sel & ~bus_we;
  assign wr_ctrl  = wr && bus_addr == OFS_CTRL;
  assign rd_ctrl  = rd && bus_addr == OFS_CTRL;
  assign wr_pb    = wr && bus_addr == OFS_PB;
  assign wr_pcdat = wr && bus_addr == OFS_PCDAT;
  assign wr_ddr   = wr && bus_addr == OFS_DDR;
  assign wr_latch = wr && bus_addr == OFS_LATCH;
  assign rd_latch = rd && bus_addr == OFS_LATCH;
  assign lat_access = wr_latch | rd_latch;

  assign ctrl_in = pio_ctrl_t'(bus_wdata[7:0]);

  pio_stra_detect #(.STAGES(SYNC_STAGES)) u_stra (
    .clk      (clk),
    .rst      (rst),
    .stra_i   (stra_i),
    .fall_sel (fall_q),
    .act_edge (act_edge),
    .act_level(act_level)
  );

  assign cap_edge = act_edge && !mode_q[1];

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_SIMPLE;
      ie_q   <= 1'b0;
      fall_q <= 1'b0;
      low_q  <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q <= ctrl_in.mode;
      ie_q   <= ctrl_in.irq_en;
      fall_q <= ctrl_in.stra_fall;
      low_q  <= ctrl_in.strb_low;
    end
  end

  // flag with two-step clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (rd_ctrl) arm_q <= flag_q;
      if (lat_access && arm_q) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end
      if (act_edge) flag_q <= 1'b1;
    end
  end

  // data registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pb_q    <= '0;
      pdat_q  <= '0;
      ddr_q   <= '0;
      latch_q <= '0;
    end else begin
      if (wr_pb)    pb_q   <= bus_wdata;
      if (wr_ddr)   ddr_q  <= bus_wdata;
      if (wr_pcdat) pdat_q <= bus_wdata;
      if (cap_edge) latch_q <= pc_i;
      if (wr_latch && mode_q[1]) begin
        latch_q <= bus_wdata;
        pdat_q  <= bus_wdata;
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view.flag      = flag_q;
    ctrl_view.irq_en    = ie_q;
    ctrl_view.mode      = mode_q;
    ctrl_view.stra_fall = fall_q;
    ctrl_view.strb_low  = low_q;
  end

  // registered read port and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= flag_q & ie_q;
      if (rd) begin
        case (bus_addr)
          OFS_CTRL:  bus_rdata <= DW'(ctrl_view);
          OFS_PCDAT: bus_rdata <= (pc_i & ~ddr_q) | (pdat_q & ddr_q);
          OFS_PB:    bus_rdata <= pb_q;
          OFS_LATCH: bus_rdata <= latch_q;
          OFS_DDR:   bus_rdata <= ddr_q;
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  pio_strb_ctrl #(.PULSE(PULSE)) u_strb (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .strb_low  (low_q),
    .ctrl_wr   (wr_ctrl),
    .new_mode  (ctrl_in.mode),
    .wr_pb     (wr_pb),
    .wr_latch  (wr_latch),
    .rd_latch  (rd_latch),
    .act_edge  (act_edge),
    .strb_o    (strb_o),
    .strb_act  (strb_act),
    .pulse_busy(pulse_busy)
  );

  pio_portc_drive #(.DW(DW)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_q),
    .act_level(act_level),
    .ddr      (ddr_q),
    .pdat     (pdat_q),
    .latch    (latch_q),
    .pc_o     (pc_o),
    .pc_oe    (pc_oe)
  );

  assign pb_o = pb_q;
endmodule

// File: rtl/pio_hs_ctrl_chk.sv
module pio_hs_ctrl_chk
  import pio_hs_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input pio_mode_e     mode,
  input logic          wr_pb,
  input logic          wr_latch,
  input logic          pulse_busy,
  input logic          strb_act,
  input logic          act_edge,
  input logic          flag,
  input logic          arm,
  input logic          ie,
  input logic          irq,
  input logic [DW-1:0] ddr,
  input logic [DW-1:0] oe
);
  assert_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SIMPLE && wr_pb) |=> pulse_busy ##1 pulse_busy);

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (rst)
    act_edge |=> flag);

  assert_irq_on_R4: assert property (@(posedge clk) disable iff (rst)
    (flag && ie) |=> irq);

  assert_irq_off_R4: assert property (@(posedge clk) disable iff (rst)
    !(flag && ie) |=> !irq);

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (flag && !arm) |=> flag);

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FULL_IN && act_edge) |=> !strb_act);

  assert_obf_set_R8: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && wr_latch) |=> strb_act);

  assert_oe_shape_R9: assert property (@(posedge clk) disable iff (rst)
    (oe != $past(ddr)) |-> (oe == '1));
endmodule

bind pio_hs_ctrl pio_hs_ctrl_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode_q),
  .wr_pb     (wr_pb),
  .wr_latch  (wr_latch),
  .pulse_busy(pulse_busy),
  .strb_act  (strb_act),
  .act_edge  (act_edge),
  .flag      (flag_q),
  .arm       (arm_q),
  .ie        (ie_q),
  .irq       (irq_o),
  .ddr       (ddr_q),
  .oe        (pc_oe)
);

// File: tb/pio_hs_ctrl_tb_top.sv
module pio_hs_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       irq_o, strb_o;
  logic       stra_i = 1'b0;
  logic [7:0] pb_o, pc_o, pc_oe;
  logic [7:0] pc_i = '0;

  int vecs = 0, bad = 0;
  bit done = 0;

  pio_hs_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .stra_i(stra_i), .strb_o(strb_o), .pb_o(pb_o),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic set_stra(input logic lvl);
    @(negedge clk);
    stra_i = lvl;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [7:0] gpio_read(input logic [7:0] pins, input logic [7:0] dr,
                                           input logic [7:0] dat);
    return (pins & ~dr) | (dat & dr);
  endfunction

  task automatic count_active(input logic act_lvl, output int n);
    n = 0;
    for (int i = 0; i < 5; i++) begin
      if (strb_o == act_lvl) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      vecs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv, exp_lat, pcv;
    int n;
    logic lvl, fall;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R10 reset state
    chk("R10 strb", {7'd0, strb_o}, 8'h00);
    chk("R10 irq", {7'd0, irq_o}, 8'h00);
    chk("R10 pc_oe", pc_oe, 8'h00);
    bus_rd(4'd0, rv); chk("R10 ctrl", rv, 8'h00);

    // R1 two-cycle pulse, active high
    bus_wr(4'd2, 8'hA5);
    count_active(1'b1, n);
    chk("R1 pulse len", 8'(n), 8'd2);
    chk("R1 pb_o", pb_o, 8'hA5);

    // R2 active-low polarity
    bus_wr(4'd0, 8'h04);
    chk("R2 idle high", {7'd0, strb_o}, 8'h01);
    bus_wr(4'd2, 8'h5A);
    count_active(1'b0, n);
    chk("R2 low pulse len", 8'(n), 8'd2);
    bus_wr(4'd0, 8'h00);

    // R3 rising capture, falling ignored
    pc_i = 8'h3C; set_stra(1);
    bus_rd(4'd3, rv); chk("R3 rise capture", rv, 8'h3C);
    bus_rd(4'd0, rv); chk("R3 flag set", rv, 8'h80);
    pc_i = 8'h11; set_stra(0);
    bus_rd(4'd3, rv); chk("R3 fall ignored", rv, 8'h3C);
    // R5 flag clear through ctrl read then latch access already done above
    bus_rd(4'd0, rv); chk("R5 flag cleared", rv, 8'h00);

    // R3 falling-edge select
    bus_wr(4'd0, 8'h08);
    pc_i = 8'h77; set_stra(1);
    bus_rd(4'd3, rv); chk("R3 rise ignored when falling", rv, 8'h3C);
    set_stra(0);
    bus_rd(4'd3, rv); chk("R3 fall capture", rv, 8'h77);
    chk("R4 irq off while disabled", {7'd0, irq_o}, 8'h00);

    // R4 interrupt
    bus_wr(4'd0, 8'hC8);
    repeat (2) @(negedge clk);
    chk("R4 irq on", {7'd0, irq_o}, 8'h01);
    bus_rd(4'd0, rv); chk("R5 ctrl write ignores flag bit", rv, 8'hC8);
    bus_rd(4'd3, rv);
    bus_rd(4'd0, rv); chk("R5 cleared by sequence", rv, 8'h48);
    repeat (2) @(negedge clk);
    chk("R4 irq drops", {7'd0, irq_o}, 8'h00);

    // R5 bare latch access does not clear
    pc_i = 8'h22; set_stra(1); set_stra(0);
    bus_rd(4'd3, rv);
    bus_rd(4'd0, rv); chk("R5 bare access keeps flag", rv, 8'hC8);
    bus_wr(4'd0, 8'h00);

    // R6 general-purpose port C
    bus_wr(4'd4, 8'h0F);
    bus_wr(4'd1, 8'h5A);
    @(negedge clk);
    chk("R6 pc_oe", pc_oe, 8'h0F);
    chk("R6 pc_o", pc_o & 8'h0F, 8'h0A);
    pc_i = 8'hC3;
    bus_rd(4'd1, rv); chk("R6 mixed read", rv, gpio_read(8'hC3, 8'h0F, 8'h5A));

    // R7 full input handshake
    bus_wr(4'd0, 8'h10);
    chk("R7 ready after entry", {7'd0, strb_o}, 8'h01);
    pc_i = 8'h81; set_stra(1);
    chk("R7 ready dropped", {7'd0, strb_o}, 8'h00);
    bus_rd(4'd3, rv); chk("R7 captured", rv, 8'h81);
    chk("R7 ready back", {7'd0, strb_o}, 8'h01);
    set_stra(0);

    // R8 full output handshake
    bus_wr(4'd0, 8'h20);
    chk("R8 idle", {7'd0, strb_o}, 8'h00);
    bus_wr(4'd4, 8'hFF);
    bus_wr(4'd3, 8'h96);
    chk("R8 data ready", {7'd0, strb_o}, 8'h01);
    @(negedge clk);
    chk("R8 pc_o", pc_o, 8'h96);
    pc_i = 8'h00; set_stra(1);
    chk("R8 ack", {7'd0, strb_o}, 8'h00);
    bus_rd(4'd3, rv); chk("R8 latch kept", rv, 8'h96);
    set_stra(0);

    // R9 three-state output
    bus_wr(4'd0, 8'h30);
    bus_wr(4'd4, 8'h00);
    bus_wr(4'd3, 8'h69);
    repeat (2) @(negedge clk);
    chk("R9 released", pc_oe, 8'h00);
    set_stra(1);
    chk("R9 driven oe", pc_oe, 8'hFF);
    chk("R9 driven data", pc_o, 8'h69);
    chk("R9 strb ack", {7'd0, strb_o}, 8'h00);
    set_stra(0);
    chk("R9 released again", pc_oe, 8'h00);

    // random simple-mode capture (R3) and port B (R1)
    bus_wr(4'd0, 8'h00);
    bus_wr(4'd4, 8'h00);
    bus_rd(4'd3, exp_lat);
    lvl = stra_i;
    for (int k = 0; k < 24; k++) begin
      fall = 1'($urandom % 2);
      bus_wr(4'd0, {4'h0, fall, 3'b000});
      pcv = 8'($urandom);
      pc_i = pcv;
      begin
        logic nl;
        nl = 1'($urandom % 2);
        set_stra(nl);
        if (nl != lvl && nl == !fall) exp_lat = pcv;
        lvl = nl;
      end
      bus_rd(4'd3, rv); chk("R3 random capture", rv, exp_lat);
      pcv = 8'($urandom);
      bus_wr(4'd2, pcv);
      chk("R1 random pb", pb_o, pcv);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule